// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block models one macrocell of a small programmable-logic device. A 27-bit configuration word sets its behaviour while it runs. It takes a sum term and a single product term from the array, and four control terms: a clock or enable term, a reset term, a set term and an output-enable term. It also takes three global clocks, a global set/reset, four global output enables and the pad input. From these it builds one storage bit, a combinational XOR result, and the value and enable that drive the pad.

The block runs on a fast sampling clock `clk`. The global clocks and the term clocks reach it as ordinary data signals. Each cycle the block picks one of them, applies the optional inversion, and compares it with the sample from the previous cycle to find an active edge. Set and reset take effect in the sampling cycle in which they are asserted. They need no edge on the selected clock.

Top module: `cpld_macrocell`

## Requirements
- R1: While `rst_n` is low, the stored bit loads the inverse of configuration bit 26 (bit 26 = 0 gives 1, bit 26 = 1 gives 0).
- R2: Clock select is {bit3, bit2, bit0}. The codes are: 000 global clock 0, 010 global clock 1, 100 global clock 2, 110 the product term, 111 `ctrl_clk`. The codes 001, 011 and 101 select no clock, so the stored bit never updates on an edge.
- R3: Bit 1 inverts the selected clock, so a falling source edge becomes the active edge. Bit 4 makes both edges of the selected clock active.
- R4: Register mode is {bit10, bit9}. In mode 00 (D flip-flop) the stored bit takes the data input on an active edge and holds at all other times.
- R5: In mode 01 (toggle) the stored bit inverts on an active edge when the data input is 1, and holds when the data input is 0.
- R6: In mode 10 (latch) the stored bit follows the data input while the selected clock, after inversion, is high, and holds while it is low.
- R7: In mode 11 (clock enable) the product term is the clock whatever the clock select says, and the bit updates only while `ctrl_clk` is 1.
- R8: Reset select {bit6, bit5} and set select {bit8, bit7} each choose: 00 product term, 01 the dedicated term (`ctrl_rst` for reset, `ctrl_set` for set), 10 `gsr`, 11 none. An active reset clears the bit and an active set makes it 1, with no clock edge needed. Reset wins when both are active.
- R9: `fb_comb` equals `sop_term` XOR a second input chosen by {bit18, bit17}: 00 gives 0, 01 the product term, 10 the inverted product term, 11 gives 1.
- R10: Bit 15 picks the data input of the storage element: 0 takes `pad_in`, 1 takes the XOR result.
- R11: Bit 19 picks the pad data: 0 takes the stored bit, 1 takes the XOR result.
- R12: Output-enable select is bits 23..20. The codes are: 0000 always on, 0001 `ctrl_oe`, 0010 the product term, 0011 to 0110 `goe[0]` to `goe[3]`, 1111 and every unlisted code off.
- R13: Code 0111 drives the pad low with the enable on. Code 1000 is open drain: `pad_out` is 0 and `pad_oe` is the inverse of the pad data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| cfg_word | input | 27 | Configuration word |
| sop_term | input | 1 | Sum term, first XOR input |
| prod_term | input | 1 | Single product term |
| ctrl_clk | input | 1 | Control term: clock source or clock enable |
| ctrl_rst | input | 1 | Control term: dedicated reset |
| ctrl_set | input | 1 | Control term: dedicated set |
| ctrl_oe | input | 1 | Control term: output enable |
| gclk | input | 3 | Global clocks |
| gsr | input | 1 | Global set/reset |
| goe | input | 4 | Global output enables |
| pad_in | input | 1 | Pad input value |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_reg | output | 1 | Stored bit, fed back to the array |
| fb_comb | output | 1 | XOR result, fed back to the array |

## Verification
Reset and set can both be active in the same sampling cycle, and either can coincide with an active clock edge. The bench raises `ctrl_rst` and `ctrl_set` together while the bit is 1 and expects 0. It then drops reset alone and expects set to return the bit to 1. It repeats this with `gsr` as the set source and the product term as the reset source, so that one product term cannot be both. Clock-enable mode tests a clock edge while the enable is low and expects the stored bit to hold.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
    localparam int CFG_W    = 27;
    localparam int NUM_GCLK = 3;
    localparam int NUM_GOE  = 4;

    typedef enum logic [1:0] {
        MODE_DFF   = 2'b00,
        MODE_TFF   = 2'b01,
        MODE_LATCH = 2'b10,
        MODE_DFFCE = 2'b11
    } reg_mode_e;

    localparam logic [2:0] CK_G0 = 3'b000;
    localparam logic [2:0] CK_G1 = 3'b010;
    localparam logic [2:0] CK_G2 = 3'b100;
    localparam logic [2:0] CK_PT = 3'b110;
    localparam logic [2:0] CK_CT = 3'b111;

    localparam logic [1:0] SRC_PT  = 2'b00;
    localparam logic [1:0] SRC_CT  = 2'b01;
    localparam logic [1:0] SRC_GSR = 2'b10;

    localparam logic [1:0] XS_ZERO = 2'b00;
    localparam logic [1:0] XS_PT   = 2'b01;
    localparam logic [1:0] XS_NPT  = 2'b10;

    localparam logic [3:0] OE_ON  = 4'h0;
    localparam logic [3:0] OE_CT  = 4'h1;
    localparam logic [3:0] OE_PT  = 4'h2;
    localparam logic [3:0] OE_G0  = 4'h3;
    localparam logic [3:0] OE_G1  = 4'h4;
    localparam logic [3:0] OE_G2  = 4'h5;
    localparam logic [3:0] OE_G3  = 4'h6;
    localparam logic [3:0] OE_LOW = 4'h7;
    localparam logic [3:0] OE_OD  = 4'h8;

    typedef struct packed {
        logic [2:0] clk_sel;
        logic       clk_inv;
        logic       dual_edge;
        logic [1:0] rst_sel;
        logic [1:0] set_sel;
        reg_mode_e  mode;
        logic       d_from_xor;
        logic [1:0] xor_sel;
        logic       pad_from_xor;
        logic [3:0] oe_sel;
        logic       init_n;
    } mc_cfg_t;

    typedef struct packed {
        logic q;
        logic clk_prev;
    } mc_state_t;

    function automatic mc_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        mc_cfg_t c;
        c.clk_sel      = {w[3], w[2], w[0]};
        c.clk_inv      = w[1];
        c.dual_edge    = w[4];
        c.rst_sel      = w[6:5];
        c.set_sel      = w[8:7];
        c.mode         = reg_mode_e'(w[10:9]);
        c.d_from_xor   = w[15];
        c.xor_sel      = w[18:17];
        c.pad_from_xor = w[19];
        c.oe_sel       = w[23:20];
        c.init_n       = w[26];
        return c;
    endfunction
endpackage

// File: rtl/mc_clk_sel.sv
`timescale 1ns/1ps
module mc_clk_sel
    import mc_pkg::*;
(
    input  logic [2:0]          sel,
    input  logic                invert,
    input  reg_mode_e           mode,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                prod_term,
    input  logic                ctrl_clk,
    output logic                clk_lvl
);
    logic raw_clk;

    always_comb begin
        if (mode == MODE_DFFCE) begin
            raw_clk = prod_term;
        end else begin
            unique case (sel)
                CK_G0:   raw_clk = gclk[0];
                CK_G1:   raw_clk = gclk[1];
                CK_G2:   raw_clk = gclk[2];
                CK_PT:   raw_clk = prod_term;
                CK_CT:   raw_clk = ctrl_clk;
                default: raw_clk = 1'b0;
            endcase
        end
        clk_lvl = raw_clk ^ invert;
    end
endmodule

// File: rtl/mc_term_sel.sv
`timescale 1ns/1ps
module mc_term_sel
    import mc_pkg::*;
(
    input  logic [1:0] xor_sel,
    input  logic       d_from_xor,
    input  logic [1:0] rst_sel,
    input  logic [1:0] set_sel,
    input  logic       sop_term,
    input  logic       prod_term,
    input  logic       pad_in,
    input  logic       ctrl_rst,
    input  logic       ctrl_set,
    input  logic       gsr,
    output logic       xor_out,
    output logic       d_in,
    output logic       rst_act,
    output logic       set_act
);
    function automatic logic pick_src(input logic [1:0] s, input logic pt,
                                      input logic ct, input logic g);
        case (s)
            SRC_PT:  return pt;
            SRC_CT:  return ct;
            SRC_GSR: return g;
            default: return 1'b0;
        endcase
    endfunction

    logic second_in;

    always_comb begin
        case (xor_sel)
            XS_ZERO: second_in = 1'b0;
            XS_PT:   second_in = prod_term;
            XS_NPT:  second_in = ~prod_term;
            default: second_in = 1'b1;
        endcase
        xor_out = sop_term ^ second_in;
        d_in    = d_from_xor ? xor_out : pad_in;
        rst_act = pick_src(rst_sel, prod_term, ctrl_rst, gsr);
        set_act = pick_src(set_sel, prod_term, ctrl_set, gsr);
    end
endmodule

// File: rtl/mc_pad_drv.sv
`timescale 1ns/1ps
module mc_pad_drv
    import mc_pkg::*;
(
    input  logic [3:0]         oe_sel,
    input  logic               pad_from_xor,
    input  logic               xor_out,
    input  logic               reg_q,
    input  logic               ctrl_oe,
    input  logic               prod_term,
    input  logic [NUM_GOE-1:0] goe,
    output logic               pad_out,
    output logic               pad_oe
);
    logic pad_data;

    always_comb begin
        pad_data = pad_from_xor ? xor_out : reg_q;
        pad_out  = pad_data;
        case (oe_sel)
            OE_ON:   pad_oe = 1'b1;
            OE_CT:   pad_oe = ctrl_oe;
            OE_PT:   pad_oe = prod_term;
            OE_G0:   pad_oe = goe[0];
            OE_G1:   pad_oe = goe[1];
            OE_G2:   pad_oe = goe[2];
            OE_G3:   pad_oe = goe[3];
            OE_LOW: begin
                pad_oe  = 1'b1;
                pad_out = 1'b0;
            end
            OE_OD: begin
                pad_oe  = ~pad_data;
                pad_out = 1'b0;
            end
            default: pad_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpld_macrocell.sv
`timescale 1ns/1ps
module cpld_macrocell
    import mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic                sop_term,
    input  logic                prod_term,
    input  logic                ctrl_clk,
    input  logic                ctrl_rst,
    input  logic                ctrl_set,
    input  logic                ctrl_oe,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                gsr,
    input  logic [NUM_GOE-1:0]  goe,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                fb_reg,
    output logic                fb_comb
);
    mc_cfg_t   cfg;
    mc_state_t st_q, st_d;
    logic      clk_lvl, xor_out, d_in, rst_act, set_act;
    logic      edge_hit, clk_en;

    assign cfg = decode_cfg(cfg_word);

    mc_clk_sel u_clk (
        .sel(cfg.clk_sel), .invert(cfg.clk_inv), .mode(cfg.mode),
        .gclk(gclk), .prod_term(prod_term), .ctrl_clk(ctrl_clk),
        .clk_lvl(clk_lvl)
    );

    mc_term_sel u_term (
        .xor_sel(cfg.xor_sel), .d_from_xor(cfg.d_from_xor),
        .rst_sel(cfg.rst_sel), .set_sel(cfg.set_sel),
        .sop_term(sop_term), .prod_term(prod_term), .pad_in(pad_in),
        .ctrl_rst(ctrl_rst), .ctrl_set(ctrl_set), .gsr(gsr),
        .xor_out(xor_out), .d_in(d_in), .rst_act(rst_act), .set_act(set_act)
    );

    mc_pad_drv u_pad (
        .oe_sel(cfg.oe_sel), .pad_from_xor(cfg.pad_from_xor),
        .xor_out(xor_out), .reg_q(st_q.q), .ctrl_oe(ctrl_oe),
        .prod_term(prod_term), .goe(goe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = clk_lvl;
        edge_hit      = cfg.dual_edge ? (clk_lvl != st_q.clk_prev)
                                      : (clk_lvl && !st_q.clk_prev);
        clk_en        = (cfg.mode != MODE_DFFCE) || ctrl_clk;
        if (!rst_n) begin
            st_d.q = ~cfg.init_n;
        end else if (rst_act) begin
            st_d.q = 1'b0;
        end else if (set_act) begin
            st_d.q = 1'b1;
        end else begin
            case (cfg.mode)
                MODE_LATCH: if (clk_lvl) st_d.q = d_in;
                MODE_TFF:   if (edge_hit) st_d.q = st_q.q ^ d_in;
                default:    if (edge_hit && clk_en) st_d.q = d_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fb_reg  = st_q.q;
    assign fb_comb = xor_out;

    // R8
    rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> !fb_reg);

    // R8
    set_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_act && !rst_act) |=> fb_reg);

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && !set_act && !edge_hit &&
         !(cfg.mode == MODE_LATCH && clk_lvl)) |=> $stable(fb_reg));

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_TFF && edge_hit && d_in && !rst_act && !set_act)
        |=> (fb_reg != $past(fb_reg)));
endmodule

// File: tb/cpld_macrocell_test.sv
`timescale 1ns/1ps
module cpld_macrocell_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [26:0] cfg = '0;
    logic        sop = 0, pt = 0, ct_clk = 0, ct_rst = 0, ct_set = 0, ct_oe = 0;
    logic [2:0]  gclk = '0;
    logic        gsr = 0, pad_in = 0;
    logic [3:0]  goe = '0;
    logic        pad_out, pad_oe, fb_reg, fb_comb;
    int          n_chk = 0, n_fail = 0;

    cpld_macrocell uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg), .sop_term(sop),
        .prod_term(pt), .ctrl_clk(ct_clk), .ctrl_rst(ct_rst),
        .ctrl_set(ct_set), .ctrl_oe(ct_oe), .gclk(gclk), .gsr(gsr),
        .goe(goe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .fb_reg(fb_reg), .fb_comb(fb_comb)
    );

    always #10 clk = ~clk;

    function automatic logic [26:0] mk(input logic [2:0] cs, input logic inv,
        input logic ddr, input logic [1:0] rs, input logic [1:0] ss,
        input logic [1:0] md, input logic ds, input logic [1:0] xs,
        input logic os, input logic [3:0] oe, input logic initv);
        logic [26:0] w = '0;
        w[0] = cs[0]; w[2] = cs[1]; w[3] = cs[2];
        w[1] = inv; w[4] = ddr; w[6:5] = rs; w[8:7] = ss; w[10:9] = md;
        w[15] = ds; w[18:17] = xs; w[19] = os; w[23:20] = oe; w[26] = ~initv;
        return w;
    endfunction

    function automatic logic [26:0] dflt(input logic [2:0] cs, input logic [1:0] md);
        return mk(cs, 0, 0, 2'b11, 2'b11, md, 1, 2'b00, 0, 4'h0, 0);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_src(input logic [4:0] s);
        gclk = s[2:0]; pt = s[3]; ct_clk = s[4];
    endtask

    task automatic do_reset(input logic [26:0] c);
        rst_n = 0; cfg = c;
        sop = 0; pt = 0; ct_clk = 0; ct_rst = 0; ct_set = 0; ct_oe = 0;
        gclk = '0; gsr = 0; goe = '0; pad_in = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic t_reset();
        rst_n = 0;
        cfg = mk(3'b000, 0, 0, 2'b11, 2'b11, 2'b00, 1, 2'b00, 0, 4'h0, 1);
        step(); step();
        chk("R1 init bit26=0", fb_reg, 1'b1);
        cfg[26] = 1'b1;
        step();
        chk("R1 init bit26=1", fb_reg, 1'b0);
        rst_n = 1;
    endtask

    task automatic t_clk_sel();
        logic [2:0] codes [5] = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b111};
        for (int k = 0; k < 5; k++) begin
            do_reset(dflt(codes[k], 2'b00));
            sop = 1; set_src(5'b0); step();
            chk("R2 no edge", fb_reg, 1'b0);
            set_src(5'b1 << k); step();
            chk($sformatf("R2 code %b", codes[k]), fb_reg, 1'b1);
        end
        do_reset(dflt(3'b001, 2'b00));
        sop = 1; set_src(5'h1F); step(); set_src(5'h00); step(); set_src(5'h1F); step();
        chk("R2 unused code 001", fb_reg, 1'b0);
    endtask

    task automatic t_inv_ddr();
        do_reset(mk(3'b000, 1, 0, 2'b11, 2'b11, 2'b00, 1, 2'b00, 0, 4'h0, 0));
        sop = 1; gclk[0] = 1; step();
        chk("R3 inverted rising ignored", fb_reg, 1'b0);
        gclk[0] = 0; step();
        chk("R3 inverted falling active", fb_reg, 1'b1);
        do_reset(mk(3'b000, 0, 1, 2'b11, 2'b11, 2'b00, 1, 2'b00, 0, 4'h0, 0));
        sop = 1; gclk[0] = 1; step();
        chk("R3 dual rising", fb_reg, 1'b1);
        sop = 0; gclk[0] = 0; step();
        chk("R3 dual falling", fb_reg, 1'b0);
        sop = 1; step();
        chk("R4 holds without edge", fb_reg, 1'b0);
    endtask

    task automatic t_dff_tff();
        do_reset(dflt(3'b000, 2'b00));
        sop = 1; gclk[0] = 1; step();
        sop = 0; step();
        chk("R4 dff holds while clock high", fb_reg, 1'b1);
        gclk[0] = 0; step(); gclk[0] = 1; step();
        chk("R4 dff captures 0", fb_reg, 1'b0);
        do_reset(dflt(3'b000, 2'b01));
        sop = 1; gclk[0] = 1; step();
        chk("R5 toggle to 1", fb_reg, 1'b1);
        gclk[0] = 0; step(); gclk[0] = 1; step();
        chk("R5 toggle to 0", fb_reg, 1'b0);
        sop = 0; gclk[0] = 0; step(); gclk[0] = 1; step();
        chk("R5 no toggle on data 0", fb_reg, 1'b0);
    endtask

    task automatic t_latch_ce();
        do_reset(dflt(3'b000, 2'b10));
        gclk[0] = 1; sop = 1; step();
        chk("R6 latch transparent 1", fb_reg, 1'b1);
        sop = 0; step();
        chk("R6 latch transparent 0", fb_reg, 1'b0);
        gclk[0] = 0; step(); sop = 1; step();
        chk("R6 latch holds", fb_reg, 1'b0);
        do_reset(dflt(3'b000, 2'b11));
        sop = 1; pt = 1; step();
        chk("R7 enable low blocks", fb_reg, 1'b0);
        pt = 0; ct_clk = 1; step();
        chk("R7 enable is not a clock", fb_reg, 1'b0);
        pt = 1; step();
        chk("R7 product term clock", fb_reg, 1'b1);
        sop = 0; gclk[0] = 1; step();
        chk("R7 global clock ignored", fb_reg, 1'b1);
    endtask

    task automatic t_set_rst();
        do_reset(mk(3'b000, 0, 0, 2'b01, 2'b01, 2'b00, 1, 2'b00, 0, 4'h0, 0));
        ct_set = 1; step();
        chk("R8 set term", fb_reg, 1'b1);
        ct_set = 0; step();
        chk("R8 holds after set", fb_reg, 1'b1);
        ct_rst = 1; ct_set = 1; step();
        chk("R8 reset wins", fb_reg, 1'b0);
        ct_rst = 0; step();
        chk("R8 set after reset drop", fb_reg, 1'b1);
        ct_set = 0;
        cfg = mk(3'b000, 0, 0, 2'b00, 2'b10, 2'b00, 1, 2'b00, 0, 4'h0, 0);
        pt = 1; gsr = 1; step();
        chk("R8 product-term reset over global set", fb_reg, 1'b0);
        pt = 0; step();
        chk("R8 global set", fb_reg, 1'b1);
        gsr = 0;
    endtask

    task automatic t_xor_paths();
        for (int xs = 0; xs < 4; xs++) begin
            for (int v = 0; v < 2; v++) begin
                logic exp;
                cfg = mk(3'b000, 0, 0, 2'b11, 2'b11, 2'b00, 1, 2'(xs), 1, 4'h0, 0);
                sop = v[0]; pt = ~v[0];
                #1;
                exp = sop ^ ((xs == 0) ? 1'b0 : (xs == 1) ? pt : (xs == 2) ? ~pt : 1'b1);
                chk($sformatf("R9 xor sel %0d", xs), fb_comb, exp);
                chk("R11 pad from xor", pad_out, exp);
                @(negedge clk);
            end
        end
        do_reset(mk(3'b000, 0, 0, 2'b11, 2'b11, 2'b00, 0, 2'b00, 0, 4'h0, 0));
        pad_in = 1; sop = 0; gclk[0] = 1; step();
        chk("R10 data from pad", fb_reg, 1'b1);
        chk("R11 pad from register", pad_out, 1'b1);
        cfg[15] = 1; gclk[0] = 0; step(); gclk[0] = 1; step();
        chk("R10 data from xor", fb_reg, 1'b0);
    endtask

    task automatic t_oe();
        do_reset(mk(3'b000, 0, 0, 2'b11, 2'b11, 2'b00, 1, 2'b00, 1, 4'h0, 0));
        sop = 1; #1;
        chk("R12 always on", pad_oe, 1'b1);
        cfg[23:20] = 4'h1; ct_oe = 1; #1; chk("R12 ctrl_oe 1", pad_oe, 1'b1);
        ct_oe = 0; #1; chk("R12 ctrl_oe 0", pad_oe, 1'b0);
        cfg[23:20] = 4'h2; pt = 1; #1; chk("R12 pt 1", pad_oe, 1'b1);
        pt = 0; #1; chk("R12 pt 0", pad_oe, 1'b0);
        for (int g = 0; g < 4; g++) begin
            cfg[23:20] = 4'(3 + g);
            goe = 4'(1 << g); #1; chk($sformatf("R12 goe%0d on", g), pad_oe, 1'b1);
            goe = ~goe; #1; chk($sformatf("R12 goe%0d off", g), pad_oe, 1'b0);
        end
        goe = 4'hF;
        cfg[23:20] = 4'hF; #1; chk("R12 disabled", pad_oe, 1'b0);
        cfg[23:20] = 4'h9; #1; chk("R12 unlisted code", pad_oe, 1'b0);
        cfg[23:20] = 4'h7; #1;
        chk("R13 drive low oe", pad_oe, 1'b1);
        chk("R13 drive low value", pad_out, 1'b0);
        cfg[23:20] = 4'h8; #1;
        chk("R13 open drain high releases", pad_oe, 1'b0);
        sop = 0; #1;
        chk("R13 open drain low drives", pad_oe, 1'b1);
        chk("R13 open drain value", pad_out, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_clk_sel();
        t_inv_ddr();
        t_dff_tff();
        t_latch_ce();
        t_set_rst();
        t_xor_paths();
        t_oe();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule